// File: doc/BRIEF.md
# Single-Cycle Byte-Coded Subset Core

This block is a small processor that completes one instruction on every clock edge. It fetches up to ten instruction bytes at once from a byte-addressed instruction port. It decodes them, reads its register file, computes a result and updates its state, all within one cycle. The register file has fifteen 64-bit registers. Besides the registers, the core holds a program counter and two condition flags: sign and zero.

The core supports six instruction classes:

- halt
- immediate load into a register
- register move and conditional move
- register store to data memory
- two-operand ALU operation
- unconditional jump

Instructions vary in length. The core computes the next program counter from each instruction's length, so no extra cycle is needed. A plain register move is the always-true case of the conditional move.

Stores go to a data port that has an address, a read strobe, a write strobe, 64-bit write data and 64-bit read data. A halt, or a byte the core does not recognise, stops the core. It then raises `halted` and keeps its state.

Top module: `bcore_top`

## Requirements
- R1: While `rst_n` is low and at the first fetch after reset, `imem_addr` is 0, `halted` is 0, and both data strobes are 0. Every register reads as 0 until it is written.
- R2: An instruction's first byte is {code[7:4], func[3:0]} and its second byte is {srcA[7:4], dst/base B[3:0]}. Each instruction takes exactly one clock. The program counter advances by the instruction length: ALU op (code 6) and move (code 2) are 2 bytes, immediate load (code 3) and store (code 4) are 10 bytes.
- R3: Immediate load (code 3) writes the little-endian 8-byte constant at PC+2 into register B.
- R4: ALU op (code 6) writes B op A into register B. The func values are 0 add, 1 subtract (B minus A), 2 and, 3 xor.
- R5: Only an ALU op updates the flags. The zero flag becomes result==0 and the sign flag becomes result bit 63. After reset the sign flag is 0 and the zero flag is 1.
- R6: The move (code 2) copies register A into register B only when its func condition holds. The conditions are: 0 always, 1 sign|zero, 2 sign, 3 zero, 4 !zero, 5 !sign, 6 !sign&!zero.
- R7: A store (code 4) performs one write in its own cycle. The address is register B plus the little-endian 8-byte displacement at PC+2, computed by the ALU adder. The write data is register A, the write strobe is 1 and the read strobe is 0. The read strobe is never raised.
- R8: A jump (code 7, 9 bytes) loads the program counter with the little-endian 8-byte constant at PC+1.
- R9: Register index 15 names no register: writes to it are dropped and reads from it return 0.
- R10: Code 0, an unknown code, an ALU func above 3, or a move func above 6 sets `halted`. From then on the program counter stays put and no store or register write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 64 | Program counter, byte address of the fetch |
| imem_rdata | input | 80 | Ten bytes starting at imem_addr, byte k in bits [8k+7:8k] |
| dmem_addr | output | 64 | Data write address |
| dmem_rd | output | 1 | Data read strobe (held low in this subset) |
| dmem_wr | output | 1 | Data write strobe |
| dmem_wdata | output | 64 | Data written to memory |
| dmem_rdata | input | 64 | Data returned by memory |
| halted | output | 1 | Core has stopped |

## Verification
The ALU path is swept with every pairing of seven operands chosen at zero, one, small positives, the most negative value, all-ones and the largest positive value, crossed with all four functions. This separates carry and borrow wrap, sign-bit results and zero results. After each ALU op, all seven move conditions are tried, with an immediate load placed in between. A true-versus-false mismatch therefore points either at the condition table or at a flag that the immediate load wrongly overwrote. Directed programs then cover the following cases:

- the post-reset flag and register values
- the store example at base 2 plus 160, and a store with a negative displacement
- a jump over a store that must never happen
- register index 15
- an unknown code, which must freeze the program counter

// File: rtl/bcore_pkg.sv
// Shared constants and types for the single-cycle byte-coded core.
// Assumes little-endian byte order within fetched words.
package bcore_pkg;
    parameter int XLEN        = 64;
    parameter int NREG        = 15;
    localparam int WBYTES     = XLEN / 8;
    localparam int FETCH_BYTES = 2 + WBYTES;
    localparam int FETCH_W    = FETCH_BYTES * 8;
    localparam int RIDX_W     = $clog2(NREG + 1);
    localparam int LEN_W      = $clog2(FETCH_BYTES + 1);

    localparam logic [3:0] CODE_HALT  = 4'h0;
    localparam logic [3:0] CODE_MOVE  = 4'h2;
    localparam logic [3:0] CODE_IMM   = 4'h3;
    localparam logic [3:0] CODE_STORE = 4'h4;
    localparam logic [3:0] CODE_ALU   = 4'h6;
    localparam logic [3:0] CODE_JUMP  = 4'h7;
    localparam logic [RIDX_W-1:0] REG_NONE = '1;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_t;

    typedef struct packed {
        logic [3:0]        code;
        logic [3:0]        func;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [XLEN-1:0]   konst;
        logic [LEN_W-1:0]  len;
        logic              legal;
    } decoded_t;
endpackage

// File: rtl/bcore_decode.sv
// Splits the fetched bytes into fields, picks the constant and the length.
// Assumes the fetch window always holds FETCH_BYTES valid bytes.
module bcore_decode
    import bcore_pkg::*;
(
    input  logic [FETCH_W-1:0] fetch_bytes,
    output decoded_t           dec
);
    logic [XLEN-1:0] const_at1;
    logic [XLEN-1:0] const_at2;

    assign const_at1 = fetch_bytes[8 +: XLEN];
    assign const_at2 = fetch_bytes[16 +: XLEN];

    // Field extraction, length and legality per instruction code
    always_comb begin
        dec.code  = fetch_bytes[7:4];
        dec.func  = fetch_bytes[3:0];
        dec.ra    = fetch_bytes[15:12];
        dec.rb    = fetch_bytes[11:8];
        dec.konst = const_at2;
        dec.len   = LEN_W'(1);
        dec.legal = 1'b0;
        case (fetch_bytes[7:4])
            CODE_HALT: begin
                dec.len   = LEN_W'(1);
                dec.legal = 1'b1;
            end
            CODE_MOVE: begin
                dec.len   = LEN_W'(2);
                dec.legal = (fetch_bytes[3:0] <= 4'd6);
            end
            CODE_IMM: begin
                dec.len   = LEN_W'(FETCH_BYTES);
                dec.legal = 1'b1;
            end
            CODE_STORE: begin
                dec.len   = LEN_W'(FETCH_BYTES);
                dec.legal = 1'b1;
            end
            CODE_ALU: begin
                dec.len   = LEN_W'(2);
                dec.legal = (fetch_bytes[3:0] <= 4'd3);
            end
            CODE_JUMP: begin
                dec.len   = LEN_W'(1 + WBYTES);
                dec.konst = const_at1;
                dec.legal = 1'b1;
            end
            default: begin
                dec.len   = LEN_W'(1);
                dec.legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcore_regfile.sv
// Register file: NREG entries, two read ports, one write port.
// Index REG_NONE (all ones) reads as zero and is never written.
module bcore_regfile
    import bcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd_idx_a,
    input  logic [RIDX_W-1:0] rd_idx_b,
    output logic [XLEN-1:0]   rd_data_a,
    output logic [XLEN-1:0]   rd_data_b,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data
);
    logic [XLEN-1:0] entry_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        // One register, cleared at reset, loaded when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[i] <= '0;
            end else if (wr_en && (wr_idx == RIDX_W'(i))) begin
                entry_q[i] <= wr_data;
            end
        end
    end

    // Read port A with the no-register index mapped to zero
    always_comb begin
        rd_data_a = '0;
        if (int'(rd_idx_a) < NREG) rd_data_a = entry_q[rd_idx_a];
    end

    // Read port B with the no-register index mapped to zero
    always_comb begin
        rd_data_b = '0;
        if (int'(rd_idx_b) < NREG) rd_data_b = entry_q[rd_idx_b];
    end
endmodule

// File: rtl/bcore_exec.sv
// ALU, the sign/zero flag register and the move-condition evaluator.
// Flags load only when cc_we is high; conditions read the stored flags.
module bcore_exec
    import bcore_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  alu_op_t         op,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            cc_we,
    input  logic [3:0]      cond_sel,
    output logic [XLEN-1:0] result,
    output logic            cond_met
);
    logic sign_q;
    logic zero_q;

    // Arithmetic and logic result, B op A
    always_comb begin
        case (op)
            OP_ADD:  result = opnd_b + opnd_a;
            OP_SUB:  result = opnd_b - opnd_a;
            OP_AND:  result = opnd_b & opnd_a;
            default: result = opnd_b ^ opnd_a;
        endcase
    end

    // Flag register: sign clear and zero set at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            zero_q <= 1'b1;
        end else if (cc_we) begin
            sign_q <= result[XLEN-1];
            zero_q <= (result == '0);
        end
    end

    // Condition table for the move family
    always_comb begin
        case (cond_sel)
            4'd0:    cond_met = 1'b1;
            4'd1:    cond_met = sign_q | zero_q;
            4'd2:    cond_met = sign_q;
            4'd3:    cond_met = zero_q;
            4'd4:    cond_met = !zero_q;
            4'd5:    cond_met = !sign_q;
            4'd6:    cond_met = !sign_q && !zero_q;
            default: cond_met = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcore_top.sv
// Single-cycle core: fetch, decode, register read, execute and update in one clock.
// Assumes imem_rdata returns the ten bytes at imem_addr combinationally.
module bcore_top
    import bcore_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [FETCH_W-1:0] imem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    output logic               dmem_rd,
    output logic               dmem_wr,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               halted
);
    decoded_t        dec;
    logic [XLEN-1:0] pc_q;
    logic            halted_q;
    logic            active;
    logic [XLEN-1:0] val_a;
    logic [XLEN-1:0] val_b;
    alu_op_t         alu_op;
    logic [XLEN-1:0] alu_a;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            cond_met;
    logic            rf_we;
    logic [XLEN-1:0] pc_next;

    bcore_decode u_decode (
        .fetch_bytes (imem_rdata),
        .dec         (dec)
    );

    bcore_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_a  (dec.ra),
        .rd_idx_b  (dec.rb),
        .rd_data_a (val_a),
        .rd_data_b (val_b),
        .wr_en     (rf_we),
        .wr_idx    (dec.rb),
        .wr_data   (alu_res)
    );

    // An instruction commits only while running and when it is not a stop
    assign active = !halted_q && dec.legal && (dec.code != CODE_HALT);

    // ALU operand and function selection per instruction code
    always_comb begin
        alu_op = OP_ADD;
        alu_a  = val_a;
        alu_b  = '0;
        case (dec.code)
            CODE_ALU: begin
                alu_op = alu_op_t'(dec.func[1:0]);
                alu_b  = val_b;
            end
            CODE_IMM:   alu_a = dec.konst;
            CODE_STORE: begin
                alu_a = dec.konst;
                alu_b = val_b;
            end
            default: ;
        endcase
    end

    bcore_exec u_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (alu_op),
        .opnd_a   (alu_a),
        .opnd_b   (alu_b),
        .cc_we    (active && (dec.code == CODE_ALU)),
        .cond_sel (dec.func),
        .result   (alu_res),
        .cond_met (cond_met)
    );

    // Register write enable for the codes that write register B
    always_comb begin
        rf_we = 1'b0;
        if (active && (dec.rb != REG_NONE)) begin
            case (dec.code)
                CODE_IMM, CODE_ALU: rf_we = 1'b1;
                CODE_MOVE:          rf_we = cond_met;
                default:            rf_we = 1'b0;
            endcase
        end
    end

    // Next program counter: jump target, sequential step, or hold
    always_comb begin
        if (!active)                     pc_next = pc_q;
        else if (dec.code == CODE_JUMP)  pc_next = dec.konst;
        else                             pc_next = pc_q + XLEN'(dec.len);
    end

    // Program counter and stop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else begin
            pc_q     <= pc_next;
            halted_q <= halted_q || !active;
        end
    end

    assign imem_addr  = pc_q;
    assign halted     = halted_q;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = val_a;
    assign dmem_wr    = active && (dec.code == CODE_STORE);
    assign dmem_rd    = 1'b0;
endmodule

// File: rtl/bcore_chk.sv
// Checker for bcore_top: port-level temporal properties, bound below.
module bcore_chk
    import bcore_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [7:0]      op_byte,
    input logic            dmem_rd,
    input logic            dmem_wr,
    input logic [XLEN-1:0] dmem_rdata,
    input logic            halted
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10
    AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr)); // R10
    AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_wr); // R10
    AST_ALU_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op_byte[7:4] == 4'h6 && op_byte[3:0] <= 4'h3)
        |=> imem_addr == $past(imem_addr) + 64'd2); // R2
    AST_STORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op_byte == 8'h40) |=> imem_addr == $past(imem_addr) + 64'd10); // R2
    AST_STORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op_byte == 8'h40) |-> dmem_wr); // R7
    AST_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd |-> (!dmem_wr && !$isunknown(dmem_rdata))); // R7
endmodule

bind bcore_top bcore_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .op_byte    (imem_rdata[7:0]),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .dmem_rdata (dmem_rdata),
    .halted     (halted)
);

// File: tb/bcore_top_tb_top.sv
`timescale 1ns/1ps
module bcore_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] imem_addr;
    logic [79:0] imem_rdata;
    logic [63:0] dmem_addr;
    logic        dmem_rd;
    logic        dmem_wr;
    logic [63:0] dmem_wdata;
    logic [63:0] dmem_rdata = 64'd0;
    logic        halted;

    int total = 0;
    int bad = 0;
    int wp = 0;
    int nw = 0;
    int cyc = 0;
    logic [7:0]  prog [1024];
    logic [63:0] wa [32];
    logic [63:0] wd [32];

    always #4 clk = ~clk;

    bcore_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .halted     (halted)
    );

    // Instruction memory model: ten bytes from the program image
    always_comb begin
        for (int k = 0; k < 10; k++)
            imem_rdata[k*8 +: 8] = prog[(int'(imem_addr[9:0]) + k) % 1024];
    end

    // Data write log
    always @(posedge clk) begin
        if (rst_n && dmem_wr && nw < 32) begin
            wa[nw] = dmem_addr;
            wd[nw] = dmem_wdata;
            nw++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 1024; i++) prog[i] = 8'hF0;
        wp = 0;
    endtask

    task automatic put8(input logic [7:0] b);
        prog[wp] = b;
        wp++;
    endtask

    task automatic put64(input logic [63:0] v);
        for (int k = 0; k < 8; k++) put8(v[k*8 +: 8]);
    endtask

    task automatic e_imm(input logic [3:0] rb, input logic [63:0] v);
        put8(8'h30); put8({4'hF, rb}); put64(v);
    endtask

    task automatic e_alu(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        put8({4'h6, fn}); put8({ra, rb});
    endtask

    task automatic e_mov(input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        put8({4'h2, fn}); put8({ra, rb});
    endtask

    task automatic e_st(input logic [3:0] ra, input logic [3:0] rb, input logic [63:0] d);
        put8(8'h40); put8({ra, rb}); put64(d);
    endtask

    task automatic e_jmp(input logic [63:0] dest);
        put8(8'h70); put64(dest);
    endtask

    // Reset the core, run until halted, count cycles
    task automatic run();
        @(negedge clk);
        rst_n = 1'b0;
        nw = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [63:0] alu_model(input int fn, input logic [63:0] a, input logic [63:0] b);
        case (fn)
            0: return b + a;
            1: return b - a;
            2: return b & a;
            default: return b ^ a;
        endcase
    endfunction

    function automatic logic cond_model(input int c, input logic s, input logic z);
        case (c)
            0: return 1'b1;
            1: return s | z;
            2: return s;
            3: return z;
            4: return !z;
            5: return !s;
            default: return !s && !z;
        endcase
    endfunction

    initial begin
        #(8ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] vals [7];
        logic [63:0] res;
        logic [63:0] haddr;
        vals[0] = 64'd0;
        vals[1] = 64'd1;
        vals[2] = 64'd7;
        vals[3] = 64'd3;
        vals[4] = 64'h8000_0000_0000_0000;
        vals[5] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[6] = 64'h7FFF_FFFF_FFFF_FFFF;
        clear_prog();

        // R1: values during reset
        repeat (2) @(negedge clk);
        chk("R1 pc in reset", imem_addr, 64'd0);
        chk("R1 halted in reset", {63'd0, halted}, 64'd0);
        chk("R1 strobes in reset", {62'd0, dmem_rd, dmem_wr}, 64'd0);

        // R4 R5 R6 R3 R2: ALU sweep with all conditions after each result
        for (int fn = 0; fn < 4; fn++) begin
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    clear_prog();
                    e_imm(4'd0, vals[i]);
                    e_imm(4'd3, vals[j]);
                    e_imm(4'd6, 64'hABC);
                    e_alu(4'(fn), 4'd0, 4'd3);
                    e_imm(4'd5, 64'd0);
                    for (int c = 0; c < 7; c++) e_mov(4'(c), 4'd6, 4'(8 + c));
                    e_st(4'd3, 4'hF, 64'h200);
                    for (int c = 0; c < 7; c++) e_st(4'(8 + c), 4'hF, 64'h208 + 64'(8 * c));
                    haddr = 64'(wp);
                    put8(8'h00);
                    run();
                    res = alu_model(fn, vals[i], vals[j]);
                    chk("R2 one instruction per clock", 64'(cyc), 64'd21);
                    chk("R2 halt address from lengths", imem_addr, haddr);
                    chk("R7 write count", 64'(nw), 64'd8);
                    chk("R4 alu result", wd[0], res);
                    chk("R7 store address", wa[0], 64'h200);
                    for (int c = 0; c < 7; c++)
                        chk("R6 R5 conditional move", wd[1 + c],
                            cond_model(c, res[63], res == 64'd0) ? 64'hABC : 64'd0);
                end
            end
        end

        // R1 R5: registers cleared by reset, flags at reset value
        clear_prog();
        for (int c = 0; c < 7; c++) e_mov(4'(c), 4'd6, 4'(8 + c));
        e_imm(4'd6, 64'h77);
        for (int c = 0; c < 7; c++) e_mov(4'(c), 4'd6, 4'(8 + c));
        for (int c = 0; c < 7; c++) e_st(4'(8 + c), 4'hF, 64'h10);
        e_st(4'd3, 4'hF, 64'h18);
        put8(8'h00);
        run();
        for (int c = 0; c < 7; c++)
            chk("R5 reset flags sign=0 zero=1", wd[c], cond_model(c, 1'b0, 1'b1) ? 64'h77 : 64'd0);
        chk("R1 register zero after reset", wd[7], 64'd0);

        // R7: base 2 plus displacement 160, then a negative displacement
        clear_prog();
        e_imm(4'd0, 64'd2);
        e_imm(4'd3, 64'd8);
        e_st(4'd3, 4'd0, 64'd160);
        e_st(4'd3, 4'd0, 64'hFFFF_FFFF_FFFF_FFFE);
        put8(8'h00);
        run();
        chk("R7 store count", 64'(nw), 64'd2);
        chk("R7 address 0xa2", wa[0], 64'hA2);
        chk("R7 data 8", wd[0], 64'd8);
        chk("R7 negative displacement", wa[1], 64'd0);
        chk("R7 read strobe low", {63'd0, dmem_rd}, 64'd0);

        // R3: little-endian constant byte order
        clear_prog();
        e_imm(4'd1, 64'h0102_0304_0506_0708);
        e_st(4'd1, 4'hF, 64'h30);
        put8(8'h00);
        run();
        chk("R3 little-endian constant", wd[0], 64'h0102_0304_0506_0708);

        // R8: jump over a store
        clear_prog();
        e_imm(4'd0, 64'h99);
        e_jmp(64'h40);
        e_st(4'd0, 4'hF, 64'h300);
        put8(8'h00);
        wp = 64;
        e_imm(4'd1, 64'h55);
        e_st(4'd1, 4'hF, 64'h308);
        put8(8'h00);
        run();
        chk("R8 skipped store absent", 64'(nw), 64'd1);
        chk("R8 target store address", wa[0], 64'h308);
        chk("R8 target store data", wd[0], 64'h55);
        chk("R8 final pc", imem_addr, 64'h54);

        // R9: register index 15 never written, reads zero
        clear_prog();
        e_imm(4'hF, 64'd5);
        e_imm(4'd1, 64'd9);
        e_alu(4'd0, 4'd1, 4'hF);
        e_st(4'hF, 4'hF, 64'h50);
        e_st(4'd1, 4'hF, 64'h58);
        put8(8'h00);
        run();
        chk("R9 index 15 reads zero", wd[0], 64'd0);
        chk("R9 index 15 address base zero", wa[0], 64'h50);
        chk("R9 other register intact", wd[1], 64'd9);

        // R10: unknown code stops the core and freezes it
        clear_prog();
        e_imm(4'd2, 64'd1);
        put8(8'h10);
        e_st(4'd2, 4'hF, 64'h60);
        put8(8'h00);
        run();
        chk("R10 halted on unknown code", {63'd0, halted}, 64'd1);
        chk("R10 pc at unknown code", imem_addr, 64'd10);
        repeat (5) @(negedge clk);
        chk("R10 pc frozen", imem_addr, 64'd10);
        chk("R10 no store after stop", 64'(nw), 64'd0);

        // R10: illegal ALU func also stops
        clear_prog();
        e_alu(4'd5, 4'd0, 4'd1);
        run();
        chk("R10 illegal alu func stops", imem_addr, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule